// File: doc/BRIEF.md
# Digest Slot Store-and-Verify Unit

This unit takes a finished message digest from a hash engine and handles the memory side of an integrity check. Each monitored region owns a 32-byte slot in a hash area in system memory. When the mode bit is clear, the unit writes the digest into the region's slot. When the mode bit is set, it reads the slot back and reports whether the stored value equals the freshly computed digest.

Digests arrive as big-endian 32-bit words on a packed input. Word 0 sits in bits 31:0, word 1 in bits 63:32, and so on. The algorithm select is 0 for SHA-1, which uses 5 words, and 1 for SHA-224, which uses 7 words. Memory is little-endian: the first byte of each digest word goes to byte lane 0.

The memory master is a single-word valid/ready channel. `mem_req` acts as valid. A transfer completes on a rising clock edge where both `mem_req` and `mem_ready` are high. The slave may hold `mem_ready` low for any number of cycles. While it does, the unit keeps the request and all of its payload frozen. Read data is sampled only in the completing cycle.

Top module: `digest_store_unit`

## Requirements
- R1: The slot base is the hash-area base with its low 7 bits forced to zero, plus the region identifier times 32. No other address bits of the base are altered.
- R2: Word k of an operation goes to the slot base plus 4*k. Words go in ascending order, with exactly one completed transfer per word: 5 words when the algorithm select is 0 (SHA-1) and 7 words when it is 1 (SHA-224).
- R3: A pending request (`mem_req` high, `mem_ready` low) stays high on the next cycle. Address, write data and `mem_we` stay unchanged.
- R4: In write mode (mode 0), every transfer has `mem_we`=1. Its write data is the digest word byte-reversed: digest bits 31:24 go to bits 7:0, and digest bits 7:0 go to bits 31:24. Example: SHA-1 "abc" produces the stored words 363e99a9, 6a810647, 71253eba, 6cc25078, 9dd8d09c.
- R5: In compare mode (mode 1), every transfer has `mem_we`=0, and memory is not modified.
- R6: `mismatch` becomes 1 if any byte-reversed word read in compare mode differs from its digest word. It stays 1 until the next accepted start, which clears it. It stays 0 in write mode.
- R7: `done` is a one-cycle pulse in the cycle after the final transfer completes. `busy` is low in that same cycle.
- R8: A start is accepted only when `busy` is low. A start while busy has no effect. Base, region, mode, algorithm and digest are all captured at acceptance.
- R9: After reset, `busy`, `done`, `mem_req` and `mismatch` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse |
| cfg_base | input | AW | Hash-area base address (low 7 bits ignored) |
| cfg_region | input | RW | Region identifier |
| cfg_cmp | input | 1 | 0 = write digest, 1 = compare against slot |
| cfg_alg | input | 1 | 0 = SHA-1 (5 words), 1 = SHA-224 (7 words) |
| digest_in | input | 224 | Digest, word k in bits 32k+31:32k, big-endian words |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| mismatch | output | 1 | Sticky compare failure flag |
| mem_req | output | 1 | Request valid |
| mem_ready | input | 1 | Slave accepts the request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid in the completing cycle |

## Verification
The assertions assume that `mem_rdata` matters only in a cycle where `mem_req` and `mem_ready` are both high. They also assume `start` may arrive at any time, including while busy. They do not assume `mem_ready` is ever high in a given window, so the hold properties must survive arbitrary stalls. The bench models the slave with a combinational read of a bench-owned memory. It drives `mem_ready` either constantly high or with a repeating stall pattern. It also injects a conflicting start in the middle of an operation, so the ignore-while-busy path is covered without breaking any of these assumptions.

// File: rtl/dsu_pkg.sv
package dsu_pkg;
  typedef enum logic {ALG_SHA1 = 1'b0, ALG_SHA224 = 1'b1} alg_e;
  typedef enum logic {ST_IDLE = 1'b0, ST_XFER = 1'b1} st_e;
  localparam int unsigned WORDS_SHA1   = 5;
  localparam int unsigned WORDS_SHA224 = 7;
  localparam int unsigned MAX_WORDS    = 7;
  localparam int unsigned WORD_BITS    = 32;
  localparam int unsigned ALIGN_BITS   = 7;
  localparam int unsigned SLOT_SHIFT   = 5;
endpackage

// File: rtl/dsu_lane_swap.sv
module dsu_lane_swap #(
  parameter int unsigned DW = 32
) (
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout
);
  localparam int unsigned NB = DW / 8;
  for (genvar b = 0; b < NB; b++) begin : g_lane
    assign dout[8*b +: 8] = din[8*(NB-1-b) +: 8];
  end
endmodule

// File: rtl/dsu_addr_gen.sv
module dsu_addr_gen #(
  parameter int unsigned AW         = 32,
  parameter int unsigned RW         = 4,
  parameter int unsigned IW         = 3,
  parameter int unsigned ALIGN_BITS = 7,
  parameter int unsigned SLOT_SHIFT = 5
) (
  input  logic [AW-1:0] base,
  input  logic [RW-1:0] region,
  input  logic [IW-1:0] idx,
  output logic [AW-1:0] addr
);
  logic [AW-1:0] base_al;
  logic [AW-1:0] slot_off;
  logic [AW-1:0] word_off;
  always_comb begin
    base_al  = {base[AW-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
    slot_off = AW'(region) << SLOT_SHIFT;
    word_off = AW'(idx) << 2;
    addr     = base_al + slot_off + word_off;
  end
endmodule

// File: rtl/dsu_cmp_acc.sv
module dsu_cmp_acc #(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          check_en,
  input  logic [DW-1:0] rd_word,
  input  logic [DW-1:0] exp_word,
  output logic          mismatch
);
  logic mm_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        mm_q <= 1'b0;
    else if (clear)    mm_q <= 1'b0;
    else if (check_en && (rd_word != exp_word)) mm_q <= 1'b1;
  end
  assign mismatch = mm_q;

  assert_mismatch_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mm_q && !clear) |=> mm_q);
  assert_mismatch_cleared_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !mm_q);
endmodule

// File: rtl/dsu_seq.sv
module dsu_seq
  import dsu_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned RW = 4,
  parameter int unsigned DW = 32,
  parameter int unsigned NW = MAX_WORDS,
  parameter int unsigned IW = $clog2(NW)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [AW-1:0]  cfg_base,
  input  logic [RW-1:0]  cfg_region,
  input  logic           cfg_cmp,
  input  logic           cfg_alg,
  input  logic [NW*DW-1:0] digest_in,
  input  logic           ready,
  output logic           req,
  output logic           busy,
  output logic           done,
  output logic           accept,
  output logic           xfer_last,
  output logic [IW-1:0]  idx,
  output logic [AW-1:0]  base_q,
  output logic [RW-1:0]  region_q,
  output logic           cmp_q,
  output logic [DW-1:0]  cur_word
);
  st_e            state;
  logic           done_q;
  logic [IW-1:0]  idx_q;
  alg_e           alg_q;
  logic [DW-1:0]  dig_q [NW];
  logic [IW-1:0]  last_idx;

  always_comb begin
    last_idx  = (alg_q == ALG_SHA224) ? IW'(WORDS_SHA224 - 1) : IW'(WORDS_SHA1 - 1);
    req       = (state == ST_XFER);
    busy      = req;
    accept    = start && (state == ST_IDLE);
    xfer_last = req && (idx_q == last_idx);
    cur_word  = dig_q[idx_q];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      done_q   <= 1'b0;
      idx_q    <= '0;
      base_q   <= '0;
      region_q <= '0;
      cmp_q    <= 1'b0;
      alg_q    <= ALG_SHA1;
      for (int k = 0; k < NW; k++) dig_q[k] <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state)
        ST_IDLE: if (start) begin
          state    <= ST_XFER;
          idx_q    <= '0;
          base_q   <= cfg_base;
          region_q <= cfg_region;
          cmp_q    <= cfg_cmp;
          alg_q    <= alg_e'(cfg_alg);
          for (int k = 0; k < NW; k++) dig_q[k] <= digest_in[k*DW +: DW];
        end
        ST_XFER: if (ready) begin
          if (idx_q == last_idx) begin
            state  <= ST_IDLE;
            done_q <= 1'b1;
          end else begin
            idx_q <= idx_q + IW'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign idx  = idx_q;
  assign done = done_q;

  assert_req_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !ready) |=> (req && $stable(idx_q) && $stable(cmp_q)));
  assert_idx_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req && ready && !xfer_last) |=> (req && idx_q == $past(idx_q) + IW'(1)));
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !busy);
  assert_done_after_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req && ready && xfer_last) |=> done_q);
  assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !(ready && xfer_last)) |=> (busy && $stable(region_q) && $stable(base_q)));
endmodule

// File: rtl/digest_store_unit.sv
module digest_store_unit
  import dsu_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned RW = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start,
  input  logic [AW-1:0]                 cfg_base,
  input  logic [RW-1:0]                 cfg_region,
  input  logic                          cfg_cmp,
  input  logic                          cfg_alg,
  input  logic [MAX_WORDS*WORD_BITS-1:0] digest_in,
  output logic                          busy,
  output logic                          done,
  output logic                          mismatch,
  output logic                          mem_req,
  input  logic                          mem_ready,
  output logic                          mem_we,
  output logic [AW-1:0]                 mem_addr,
  output logic [WORD_BITS-1:0]          mem_wdata,
  input  logic [WORD_BITS-1:0]          mem_rdata
);
  localparam int unsigned DW = WORD_BITS;
  localparam int unsigned NW = MAX_WORDS;
  localparam int unsigned IW = $clog2(NW);

  logic          accept, xfer_last, cmp_q;
  logic [IW-1:0] idx;
  logic [AW-1:0] base_q;
  logic [RW-1:0] region_q;
  logic [DW-1:0] cur_word, swapped;

  dsu_seq #(.AW(AW), .RW(RW), .DW(DW), .NW(NW), .IW(IW)) seq_i (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_base(cfg_base),
    .cfg_region(cfg_region), .cfg_cmp(cfg_cmp), .cfg_alg(cfg_alg),
    .digest_in(digest_in), .ready(mem_ready), .req(mem_req), .busy(busy),
    .done(done), .accept(accept), .xfer_last(xfer_last), .idx(idx),
    .base_q(base_q), .region_q(region_q), .cmp_q(cmp_q), .cur_word(cur_word)
  );

  dsu_addr_gen #(.AW(AW), .RW(RW), .IW(IW), .ALIGN_BITS(ALIGN_BITS),
                 .SLOT_SHIFT(SLOT_SHIFT)) addr_i (
    .base(base_q), .region(region_q), .idx(idx), .addr(mem_addr)
  );

  dsu_lane_swap #(.DW(DW)) swap_i (.din(cur_word), .dout(swapped));

  dsu_cmp_acc #(.DW(DW)) cmp_i (
    .clk(clk), .rst_n(rst_n), .clear(accept),
    .check_en(mem_req && mem_ready && cmp_q),
    .rd_word(mem_rdata), .exp_word(swapped), .mismatch(mismatch)
  );

  assign mem_we    = mem_req && !cmp_q;
  assign mem_wdata = swapped;

  assert_payload_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_wdata) && $stable(mem_we)));
  assert_word_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[1:0] == 2'b00));
  assert_write_mode_clean_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |=> !mismatch);
  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req);
endmodule

// File: tb/digest_store_unit_tb_top.sv
module digest_store_unit_tb_top;
  localparam int AW = 32;
  localparam int RW = 4;
  localparam int NW = 7;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0, start = 1'b0, cfg_cmp = 1'b0, cfg_alg = 1'b0;
  logic [AW-1:0] cfg_base = '0;
  logic [RW-1:0] cfg_region = '0;
  logic [NW*32-1:0] digest_in = '0;
  logic busy, done, mismatch, mem_req, mem_we;
  logic mem_ready = 1'b0;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;

  digest_store_unit #(.AW(AW), .RW(RW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_base(cfg_base),
    .cfg_region(cfg_region), .cfg_cmp(cfg_cmp), .cfg_alg(cfg_alg),
    .digest_in(digest_in), .busy(busy), .done(done), .mismatch(mismatch),
    .mem_req(mem_req), .mem_ready(mem_ready), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  int checks = 0, errors = 0;
  logic [31:0] bmem [0:255];
  assign mem_rdata = bmem[mem_addr[9:2]];

  logic [AW-1:0] e_base;
  logic [RW-1:0] e_region;
  logic e_cmp, e_alg, stall;
  logic [NW*32-1:0] e_dig;
  int hs_count = 0;
  int cyc = 0;

  function automatic logic [31:0] rev(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction
  function automatic int nwords(input logic alg);
    return alg ? 7 : 5;
  endfunction
  function automatic logic [AW-1:0] slot_addr(input logic [AW-1:0] b, input logic [RW-1:0] r, input int k);
    return (b & ~AW'(127)) + AW'(r) * 32 + AW'(k) * 4;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // slave model and transfer monitor
  always begin
    @(negedge clk);
    cyc++;
    mem_ready = stall ? ((cyc % 3) != 0) : 1'b1;
    #1;
    if (rst_n && mem_req && mem_ready) begin
      chk(hs_count < nwords(e_alg), "R2 transfer count", 32'(hs_count), 32'(nwords(e_alg)));
      chk(mem_addr == slot_addr(e_base, e_region, hs_count), "R1/R2 address", mem_addr,
          slot_addr(e_base, e_region, hs_count));
      chk(mem_we == !e_cmp, "R4/R5 direction", 32'(mem_we), 32'(!e_cmp));
      if (!e_cmp) begin
        chk(mem_wdata == rev(e_dig[hs_count*32 +: 32]), "R4 write data", mem_wdata,
            rev(e_dig[hs_count*32 +: 32]));
      end
      if (mem_we) bmem[mem_addr[9:2]] = mem_wdata;
      hs_count++;
    end
  end

  // pending request must hold its payload
  logic [AW-1:0] p_addr;
  logic [31:0] p_wdata;
  logic p_pend = 1'b0;
  always @(negedge clk) begin
    #2;
    if (p_pend) begin
      chk(mem_req && mem_addr == p_addr && mem_wdata == p_wdata, "R3 hold", mem_addr, p_addr);
    end
    p_pend = rst_n && mem_req && !mem_ready;
    p_addr = mem_addr;
    p_wdata = mem_wdata;
  end

  task automatic run_op(input logic [AW-1:0] b, input logic [RW-1:0] r, input logic cmp,
                        input logic alg, input logic [NW*32-1:0] dig, input logic stl,
                        input bit inject);
    logic exp_mm;
    bit seen;
    int n;
    n = nwords(alg);
    exp_mm = 1'b0;
    if (cmp) for (int k = 0; k < n; k++)
      if (bmem[slot_addr(b, r, k) >> 2] != rev(dig[k*32 +: 32])) exp_mm = 1'b1;
    e_base = b; e_region = r; e_cmp = cmp; e_alg = alg; e_dig = dig; stall = stl;
    hs_count = 0;
    @(negedge clk);
    start = 1'b1; cfg_base = b; cfg_region = r; cfg_cmp = cmp; cfg_alg = alg; digest_in = dig;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R8 accepted", 32'(busy), 32'd1);
    chk(mismatch == 1'b0, "R6 cleared at start", 32'(mismatch), 32'd0);
    if (inject) begin
      @(negedge clk);
      start = 1'b1; cfg_region = ~r; cfg_cmp = ~cmp; cfg_base = b ^ 32'h100; cfg_alg = ~alg;
      digest_in = ~dig;
      @(negedge clk);
      start = 1'b0;
    end
    seen = 0;
    for (int t = 0; t < 200 && !seen; t++) begin
      @(negedge clk);
      #3;
      if (done) seen = 1;
    end
    chk(seen, "R7 done seen", 32'(seen), 32'd1);
    chk(busy == 1'b0, "R7 idle with done", 32'(busy), 32'd0);
    chk(hs_count == n, "R2 word count", 32'(hs_count), 32'(n));
    chk(mismatch == exp_mm, cmp ? "R6 compare result" : "R5/R6 write leaves flag", 32'(mismatch), 32'(exp_mm));
    @(negedge clk);
    #3;
    chk(done == 1'b0, "R7 single pulse", 32'(done), 32'd0);
    if (inject) begin
      for (int t = 0; t < 4; t++) @(negedge clk);
      chk(busy == 1'b0 && hs_count == n, "R8 start while busy ignored", 32'(hs_count), 32'(n));
    end
  endtask

  function automatic logic [NW*32-1:0] pat(input int seed);
    logic [NW*32-1:0] d;
    for (int k = 0; k < NW; k++) d[k*32 +: 32] = 32'h9e3779b9 * (seed + 1) + 32'h01010101 * k;
    return d;
  endfunction

  bit wd_fired = 0;
  initial begin
    #(10 * 150000);
    wd_fired = 1;
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [NW*32-1:0] sha1_abc, sha224_abc;
    logic [31:0] ref1 [5];
    logic [31:0] ref2 [7];
    logic [AW-1:0] bases [2];
    for (int i = 0; i < 256; i++) bmem[i] = '0;
    e_alg = 0; e_cmp = 0; e_base = 0; e_region = 0; e_dig = 0; stall = 0;
    repeat (3) @(negedge clk);
    #3;
    // R9 reset state
    chk(!busy && !done && !mem_req && !mismatch, "R9 reset state",
        {28'd0, busy, done, mem_req, mismatch}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // reference vectors, R4
    sha1_abc = '0;
    sha1_abc[0*32 +: 32] = 32'ha9993e36; sha1_abc[1*32 +: 32] = 32'h4706816a;
    sha1_abc[2*32 +: 32] = 32'hba3e2571; sha1_abc[3*32 +: 32] = 32'h7850c26c;
    sha1_abc[4*32 +: 32] = 32'h9cd0d89d;
    ref1 = '{32'h363e99a9, 32'h6a810647, 32'h71253eba, 32'h6cc25078, 32'h9dd8d09c};
    sha224_abc = '0;
    sha224_abc[0*32 +: 32] = 32'h23097d22; sha224_abc[1*32 +: 32] = 32'h3405d822;
    sha224_abc[2*32 +: 32] = 32'h8642a477; sha224_abc[3*32 +: 32] = 32'hbda255b3;
    sha224_abc[4*32 +: 32] = 32'h2aadbce4; sha224_abc[5*32 +: 32] = 32'hbda0b3f7;
    sha224_abc[6*32 +: 32] = 32'he36c9da7;
    ref2 = '{32'h227d0923, 32'h22d80534, 32'h77a44286, 32'hb355a2bd, 32'he4bcad2a,
             32'hf7b3a0bd, 32'ha79d6ce3};
    run_op(32'h0000_0100, 4'd3, 1'b0, 1'b0, sha1_abc, 1'b0, 0);
    for (int k = 0; k < 5; k++)
      chk(bmem[(32'h100 + 3*32 + k*4) >> 2] == ref1[k], "R4 SHA-1 vector",
          bmem[(32'h100 + 3*32 + k*4) >> 2], ref1[k]);
    run_op(32'h0000_017f, 4'd5, 1'b0, 1'b1, sha224_abc, 1'b1, 0);
    for (int k = 0; k < 7; k++)
      chk(bmem[(32'h100 + 5*32 + k*4) >> 2] == ref2[k], "R1 R4 SHA-224 vector",
          bmem[(32'h100 + 5*32 + k*4) >> 2], ref2[k]);
    run_op(32'h0000_0100, 4'd3, 1'b1, 1'b0, sha1_abc, 1'b1, 0);

    // R8 conflicting start during an operation
    run_op(32'h0000_0080, 4'd2, 1'b0, 1'b1, pat(77), 1'b0, 1);
    run_op(32'h0000_0080, 4'd2, 1'b1, 1'b1, pat(77), 1'b1, 1);

    // sweep: base, algorithm, region; write, matching compare, corrupted compare
    bases = '{32'h0000_00db, 32'h0000_027f};
    for (int bi = 0; bi < 2; bi++)
      for (int a = 0; a < 2; a++)
        for (int r = 0; r < 16; r++) begin
          logic [NW*32-1:0] d;
          int bad;
          d = pat(bi * 100 + a * 20 + r);
          run_op(bases[bi], RW'(r), 1'b0, a[0], d, r[0], 0);
          run_op(bases[bi], RW'(r), 1'b1, a[0], d, ~r[0], 0);
          bad = r % nwords(a[0]);
          bmem[slot_addr(bases[bi], RW'(r), bad) >> 2] ^= (32'h1 << r);
          run_op(bases[bi], RW'(r), 1'b1, a[0], d, r[1], 0);
          // R6: flag clears at the next accepted start even after a failure
          bmem[slot_addr(bases[bi], RW'(r), bad) >> 2] ^= (32'h1 << r);
        end
    run_op(bases[1], 4'd15, 1'b1, 1'b1, pat(100 + 20 + 15), 1'b0, 0);

    if (!wd_fired) begin
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule